// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one channel of an up-counting compare match timer. Software configures it through a small write-only register port. It sets a compare value, a count mode, an interrupt enable and a tick divider, and then sets the start bit. While the channel runs, the counter advances once per prescaled tick. On the tick where the counter equals the compare value, the counter returns to zero and a match flag is raised.

In one-shot mode the channel stops itself after the first match. In free-running mode it keeps counting from zero, so a match recurs every compare+1 ticks. When the compare value is all ones, a match also raises an overflow flag. The interrupt line follows the match flag, gated by the enable bit. Flags are cleared by writing zeros to the status register. Counter, flags and running state are visible directly on output ports.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter is 0, both flags are 0, the channel is stopped, the interrupt is low, the control fields are 0 and the compare value is all ones.
- R2: Register addresses are: 0 control, 1 status, 2 compare, 3 counter. Control bits are: bit0 start, bit1 mode (1 = free-running, 0 = one-shot), bit2 interrupt enable, bits 4:3 divider select. The counter does not move until a control write sets bit0.
- R3: While running, writes to the compare and counter registers are ignored, and a control write changes only bit0.
- R4: On a tick where the counter equals the compare value, the counter becomes 0 and the match flag (status bit0) is set.
- R5: In one-shot mode, a match clears the start bit, and the counter then holds at 0.
- R6: In free-running mode, counting continues from 0 after a match, so matches recur every compare+1 ticks.
- R7: The overflow flag (status bit1) is set only by a match whose compare value is all ones.
- R8: Divider select values 0, 1, 2 and 3 give one tick every 1, 4, 16 and 64 clocks of running.
- R9: A status write clears each flag whose data bit is 0 and leaves a flag whose data bit is 1 unchanged. A match in the same cycle as a clear leaves the flag set.
- R10: The interrupt output equals the match flag ANDed with the interrupt enable bit.
- R11: Writing 0 to bit0 stops counting and holds the counter value. While stopped, a write to the counter register loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| match_flag_o | output | 1 | Compare-match flag |
| ovf_flag_o | output | 1 | Overflow flag |
| running_o | output | 1 | Start bit state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CNT_W = 8. At that width, an all-ones compare value matches after only 256 ticks, so the overflow path and the reset-value compare can be run to completion. The small width also keeps runs at the 64-clock divider short enough to observe several matches. At each clock, a behavioural model, which includes the prescaler phase and same-cycle flag clears, predicts every output.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int PRE_W = 6;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_CMP  = 2'd2,
        A_CNT  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        DIV_1  = 2'd0,
        DIV_4  = 2'd1,
        DIV_16 = 2'd2,
        DIV_64 = 2'd3
    } div_sel_e;

    typedef struct packed {
        div_sel_e div;
        logic     irq_en;
        logic     free_run;
        logic     start;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [PRE_W-1:0] div_mask(div_sel_e d);
        case (d)
            DIV_1:   return 6'd0;
            DIV_4:   return 6'd3;
            DIV_16:  return 6'd15;
            default: return 6'd63;
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  div_sel_e div,
    output logic     tick
);
    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(div);
    assign tick = run && ((phase & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    // R8: a stopped channel restarts its prescaler phase from zero
    a_r8_phase_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> phase == '0);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             wrap
);
    assign match = tick && (cnt == cmp);
    assign wrap  = match && (&cmp);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (match) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    a_r4_clear_on_match: assert property (@(posedge clk) disable iff (rst)
        match |=> cnt == '0);

    a_r6_step_on_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && !match && !load) |=> cnt == $past(cnt) + 1'b1);

    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             match,
    input  logic             wrap,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cmp,
    output logic             cmf,
    output logic             ovf,
    output logic             cnt_load
);
    reg_addr_e addr;
    logic      wr_ctrl, wr_stat, wr_cmp;

    assign addr     = reg_addr_e'(wr_addr);
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_stat  = wr_en && (addr == A_STAT);
    assign wr_cmp   = wr_en && (addr == A_CMP) && !ctrl.start;
    assign cnt_load = wr_en && (addr == A_CNT) && !ctrl.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cmp  <= '1;
            cmf  <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                if (ctrl.start) ctrl.start <= wr_data[0];
                else            ctrl       <= ctrl_t'(wr_data[CTRL_W-1:0]);
            end
            if (match && !ctrl.free_run) ctrl.start <= 1'b0;
            if (wr_cmp) cmp <= wr_data;
            if (wr_stat) begin
                cmf <= cmf & wr_data[0];
                ovf <= ovf & wr_data[1];
            end
            if (match) cmf <= 1'b1;
            if (wrap)  ovf <= 1'b1;
        end
    end

    a_r3_cmp_locked: assert property (@(posedge clk) disable iff (rst)
        ctrl.start |=> $stable(cmp));

    a_r3_mode_locked: assert property (@(posedge clk) disable iff (rst)
        ctrl.start |=> (ctrl.free_run == $past(ctrl.free_run)) && (ctrl.div == $past(ctrl.div)));

    a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (match && !ctrl.free_run) |=> !ctrl.start);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        match |=> cmf);

    a_r7_ovf_all_ones: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (&cmp));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             match_flag_o,
    output logic             ovf_flag_o,
    output logic             running_o,
    output logic             irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp;
    logic             cmf, ovf, cnt_load, tick, match, wrap;

    cmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .match(match), .wrap(wrap), .ctrl(ctrl),
        .cmp(cmp), .cmf(cmf), .ovf(ovf), .cnt_load(cnt_load)
    );

    cmt_prescaler u_pre (
        .clk(clk), .rst(rst), .run(ctrl.start), .div(ctrl.div), .tick(tick)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cmp(cmp), .load(cnt_load),
        .load_val(wr_data), .cnt(count_o), .match(match), .wrap(wrap)
    );

    assign match_flag_o = cmf;
    assign ovf_flag_o   = ovf;
    assign running_o    = ctrl.start;
    assign irq_o        = cmf & ctrl.irq_en;

    a_r2_idle_no_count: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !cnt_load) |=> $stable(count_o));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> match_flag_o);

endmodule

// File: tb/cmt_channel_bench.sv
`timescale 1ns/1ps
module cmt_channel_bench;
    localparam int CW = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] count_o;
    logic          match_flag_o, ovf_flag_o, running_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // model state
    int m_cnt, m_cmp, m_pre, m_div;
    bit m_cmf, m_ovf, m_start, m_mode, m_ie;

    always #4 clk = ~clk;

    cmt_channel #(.CNT_W(CW)) u_cmt_channel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .match_flag_o(match_flag_o),
        .ovf_flag_o(ovf_flag_o), .running_o(running_o), .irq_o(irq_o)
    );

    function automatic int divisor(int d);
        case (d)
            0: return 1;
            1: return 4;
            2: return 16;
            default: return 64;
        endcase
    endfunction

    // behavioural reference, evaluated once per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_cmp = MAXV; m_pre = 0; m_div = 0;
            m_cmf = 0; m_ovf = 0; m_start = 0; m_mode = 0; m_ie = 0;
        end else begin
            bit run0, mode0, tk, hit, load;
            int d;
            run0 = m_start; mode0 = m_mode; d = int'(wr_data);
            tk = run0 && (((m_pre + 1) % divisor(m_div)) == 0);
            m_pre = run0 ? (m_pre + 1) % 64 : 0;
            hit = tk && (m_cnt == m_cmp);
            load = 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: if (run0) m_start = d[0];
                          else begin
                              m_start = d[0]; m_mode = d[1]; m_ie = d[2]; m_div = (d >> 3) & 3;
                          end
                    2'd1: begin m_cmf = m_cmf & d[0]; m_ovf = m_ovf & d[1]; end
                    2'd2: if (!run0) m_cmp = d;
                    default: if (!run0) load = 1;
                endcase
            end
            if (load) m_cnt = d;
            else if (hit) m_cnt = 0;
            else if (tk) m_cnt = (m_cnt + 1) & MAXV;
            if (hit) begin
                m_cmf = 1;
                if (m_cmp == MAXV) m_ovf = 1;
                if (!mode0) m_start = 0;
            end
        end
    end

    task automatic report(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every output on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            report(cur_req, "count", int'(count_o), m_cnt);
            report(cur_req, "match flag", int'(match_flag_o), int'(m_cmf));
            report(cur_req, "ovf flag", int'(ovf_flag_o), int'(m_ovf));
            report(cur_req, "running", int'(running_o), int'(m_start));
            report("R10", "irq", int'(irq_o), int'(m_cmf & m_ie));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int ctrl_word(int start, int mode, int ie, int dv);
        return start | (mode << 1) | (ie << 2) | (dv << 3);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        report("R1", "reset count", int'(count_o), 0);
        report("R1", "reset flags", int'({match_flag_o, ovf_flag_o, irq_o, running_o}), 0);

        // R2 configure without start: nothing moves
        cur_req = "R2";
        wr(2, 5);
        wr(0, ctrl_word(0, 1, 1, 0));
        idle(6);
        report("R2", "idle count", int'(count_o), 0);
        wr(0, ctrl_word(1, 1, 1, 0));

        // R4/R6 free run, compare 5
        cur_req = "R6";
        idle(7);
        report("R4", "match flag after period", int'(match_flag_o), 1);
        report("R10", "irq with enable", int'(irq_o), 1);
        idle(20);

        // R9 flag clears at varying phases, some coinciding with matches
        cur_req = "R9";
        for (int i = 0; i < 12; i++) begin
            wr(1, 2);
            idle(i % 4);
        end

        // R3 locked writes while running
        cur_req = "R3";
        wr(2, 2);
        wr(3, 100);
        wr(0, ctrl_word(1, 0, 0, 3));
        idle(14);
        report("R3", "still running", int'(running_o), 1);

        // R11 stop, hold, load
        cur_req = "R11";
        wr(0, 0);
        idle(5);
        begin
            logic [CW-1:0] held;
            held = count_o;
            idle(5);
            report("R11", "held count", int'(count_o), int'(held));
        end
        wr(3, 3);
        report("R11", "loaded count", int'(count_o), 3);
        wr(1, 0);

        // R5 one-shot with divider 4, compare 4
        cur_req = "R5";
        wr(2, 4);
        wr(0, ctrl_word(1, 0, 0, 1));
        idle(60);
        report("R5", "stopped after match", int'(running_o), 0);
        report("R5", "count held at zero", int'(count_o), 0);
        report("R10", "irq masked", int'(irq_o), 0);

        // R8 dividers 16 and 64, free running
        cur_req = "R8";
        wr(1, 0);
        wr(2, 3);
        wr(0, ctrl_word(1, 1, 1, 2));
        idle(200);
        wr(0, 0);
        wr(0, ctrl_word(1, 1, 1, 3));
        idle(600);
        report("R7", "no overflow below all ones", int'(ovf_flag_o), 0);

        // R7 all-ones compare
        cur_req = "R7";
        wr(0, 0);
        wr(2, MAXV);
        wr(3, MAXV - 3);
        wr(1, 0);
        wr(0, ctrl_word(1, 1, 0, 0));
        idle(6);
        report("R7", "overflow flag", int'(ovf_flag_o), 1);
        wr(1, 1);
        report("R9", "ovf cleared, match kept", int'({match_flag_o, ovf_flag_o}), 2);
        idle(300);

        idle(2);
        summary();
        $finish;
    end
endmodule